// File: doc/BRIEF.md
# Cascaded Three-Bank Interrupt Controller

This block gathers twenty-four level-sensitive interrupt lines into three slave banks of eight. Each bank holds its own enable mask and in-service state, and each feeds one cascade input of a master stage. The master picks the winning bank and drives a single request line to the processor. Software reads a dedicated acknowledge address to claim the winning source. That read returns the global source number, records the source as in service in both the slave and the master, and latches an interrupt vector of the form 0x800 + 16 × index.

Software owns the whole handshake through a small byte-wide register bus with a three-bit address. To retire an interrupt it writes a specific end-of-interrupt byte to the slave bank, then a second one to the master for that bank's cascade line. Sources are level-sensitive, so a line that is still high once both in-service bits are cleared raises the request again.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1 (all sources disabled), all in-service bits are 0, `cpu_irq` is 0 and `irq_vector` is 0.
- R2: Address 4+k (k = 0, 1, 2) reads and writes the mask of bank k, which covers global sources 8k..8k+7, with bit n for source 8k+n. A mask bit of 1 keeps its source from raising `cpu_irq`. Address k reads the raw input levels of bank k whatever the mask holds.
- R3: Banks 0, 1 and 2 sit on master cascade lines 1, 3 and 4. Among requests that are eligible, the lowest master line wins, and inside that bank the lowest bit wins. This makes the lowest unmasked global index the winner.
- R4: A read of address 7 while `cpu_irq` is 1 returns the winning global index b, marks that source in service in its slave and its master line, and from the next cycle shows `irq_vector` = 0x800 + 16·b. With `cpu_irq` at 0 the read returns 0xFF and changes nothing. At all other times `irq_vector` holds its value.
- R5: An in-service slave bit blocks its own line and every higher-numbered line of that bank. An in-service master line blocks its own line and every higher-numbered master line.
- R6: A write to address k (slave bank k) or to address 3 (master) whose byte is 0xE0 | n clears in-service bit n there and nothing else. Any byte whose upper five bits are not 11100 is ignored. Clearing a bit that is not set has no effect.
- R7: A source still asserted once its slave and master in-service bits have been cleared requests again.
- R8: Address 3 reads the master in-service byte. Bit m is set while cascade line m is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 24 | Level interrupt sources, global index 0..23 |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (matters only for address 7) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| cpu_irq | output | 1 | Interrupt request to the processor |
| irq_vector | output | 12 | Vector latched on acknowledge |

## Verification
The assertions take for granted that a bus cycle is either a read or a write and never both at once. They also assume an acknowledge read lasts exactly one cycle, so that the returned index and the vector latch describe the same winner. The stimulus issues every bus operation as one isolated cycle with idle cycles around it. It changes source levels only between bus operations, so an acknowledge never sees the winner move while it is being claimed.

// File: rtl/casc_irq_pkg.sv
// Package: shared constants of the cascaded interrupt controller.
// Assumes three slave banks of eight lines behind an eight-line master.
package casc_irq_pkg;
    localparam int BANKS      = 3;
    localparam int LINES      = 8;
    localparam int LW         = $clog2(LINES);
    localparam int MLINES     = 8;
    localparam int MW         = $clog2(MLINES);
    localparam int SRC_N      = BANKS * LINES;
    localparam int ADDR_W     = 3;
    localparam int IDX_W      = 8;
    localparam int VEC_W      = 12;
    localparam int VEC_BASE   = 'h800;
    localparam int VEC_SHIFT  = 4;
    localparam logic [4:0] EOI_TAG = 5'b11100;

    typedef enum logic [ADDR_W-1:0] {
        A_BANK0 = 3'd0, A_BANK1 = 3'd1, A_BANK2 = 3'd2, A_MASTER = 3'd3,
        A_MASK0 = 3'd4, A_MASK1 = 3'd5, A_MASK2 = 3'd6, A_ACK = 3'd7
    } reg_addr_e;

    // Master cascade line that each slave bank is wired to.
    function automatic int casc_line(input int k);
        case (k)
            0:       return 1;
            1:       return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/casc_irq_prio.sv
// Fixed-priority resolver: line 0 is highest. An in-service bit blocks
// its own line and all higher-numbered lines (fully nested order).
// Purely combinational; assumes req is already masked.
module casc_irq_prio #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] isr,
    output logic         any,
    output logic [W-1:0] win
);
    // Scan upward, stopping at the first in-service bit or eligible request.
    always_comb begin
        logic seen;
        seen = 1'b0;
        any  = 1'b0;
        win  = '0;
        for (int j = 0; j < N; j++) begin
            seen = seen | isr[j];
            if (!any && !seen && req[j]) begin
                any = 1'b1;
                win = W'(j);
            end
        end
    end
endmodule

// File: rtl/casc_irq_bank.sv
// Slave bank: mask register, in-service register and priority resolver.
// Assumes take and eoi_we are never high in the same cycle.
module casc_irq_bank #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    input  logic         eoi_we,
    input  logic [W-1:0] eoi_line,
    input  logic         take,
    output logic [N-1:0] mask_q,
    output logic         req,
    output logic [W-1:0] win
);
    logic [N-1:0] isr_q;

    // Mask register; reset disables every line.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wd;
    end

    // In-service bits: set on acknowledge, cleared by specific EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)      isr_q <= '0;
        else if (take)   isr_q <= isr_q | (N'(1) << win);
        else if (eoi_we) isr_q <= isr_q & ~(N'(1) << eoi_line);
    end

    casc_irq_prio #(.N(N), .W(W)) i_prio (
        .req (lvl & ~mask_q),
        .isr (isr_q),
        .any (req),
        .win (win)
    );
endmodule

// File: rtl/casc_irq_master.sv
// Master stage: in-service register over the cascade lines plus resolver.
// Assumes unused cascade inputs are tied low by the parent.
module casc_irq_master #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic         eoi_we,
    input  logic [W-1:0] eoi_line,
    input  logic         take,
    output logic [N-1:0] isr_q,
    output logic         any,
    output logic [W-1:0] win
);
    // Master in-service bits: set on acknowledge, cleared by specific EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)      isr_q <= '0;
        else if (take)   isr_q <= isr_q | (N'(1) << win);
        else if (eoi_we) isr_q <= isr_q & ~(N'(1) << eoi_line);
    end

    casc_irq_prio #(.N(N), .W(W)) i_prio (
        .req (req_in),
        .isr (isr_q),
        .any (any),
        .win (win)
    );
endmodule

// File: rtl/casc_irq_ctrl.sv
// Top: three slave banks cascaded into a master, byte register bus,
// acknowledge read that latches vector 0x800 + 16*index.
// Assumes a bus cycle is a read or a write, never both.
module casc_irq_ctrl
    import casc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_lvl,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 cpu_irq,
    output logic [VEC_W-1:0]     irq_vector
);
    logic [BANKS-1:0]  b_req;
    logic [LW-1:0]     b_win [BANKS];
    logic [SRC_N-1:0]  mask_flat;
    logic [MLINES-1:0] m_req;
    logic [MLINES-1:0] m_isr;
    logic              m_any;
    logic [MW-1:0]     m_win;
    logic [IDX_W-1:0]  glob_idx;
    logic              ack_take;
    logic              eoi_ok;

    assign eoi_ok   = (bus_wdata[7:3] == EOI_TAG);
    assign ack_take = bus_rd && (bus_addr == A_ACK) && m_any;
    assign cpu_irq  = m_any;

    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        logic [LINES-1:0] mask_k;
        casc_irq_bank #(.N(LINES), .W(LW)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (src_lvl[k*LINES +: LINES]),
            .mask_we  (bus_wr && bus_addr == ADDR_W'(4 + k)),
            .mask_wd  (bus_wdata),
            .eoi_we   (bus_wr && eoi_ok && bus_addr == ADDR_W'(k)),
            .eoi_line (bus_wdata[LW-1:0]),
            .take     (ack_take && m_win == MW'(casc_line(k))),
            .mask_q   (mask_k),
            .req      (b_req[k]),
            .win      (b_win[k])
        );
        assign mask_flat[k*LINES +: LINES] = mask_k;
    end

    // Place each bank request on its master cascade line.
    always_comb begin
        m_req = '0;
        for (int k = 0; k < BANKS; k++) m_req[casc_line(k)] = b_req[k];
    end

    casc_irq_master #(.N(MLINES), .W(MW)) i_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (m_req),
        .eoi_we   (bus_wr && eoi_ok && bus_addr == A_MASTER),
        .eoi_line (bus_wdata[MW-1:0]),
        .take     (ack_take),
        .isr_q    (m_isr),
        .any      (m_any),
        .win      (m_win)
    );

    // Map the winning master line back to a global source index.
    always_comb begin
        glob_idx = '0;
        for (int k = 0; k < BANKS; k++)
            if (m_win == MW'(casc_line(k)))
                glob_idx = IDX_W'(k * LINES) + IDX_W'(b_win[k]);
    end

    // Vector register, loaded only by a successful acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_vector <= '0;
        else if (ack_take) irq_vector <= VEC_W'(VEC_BASE) + (VEC_W'(glob_idx) << VEC_SHIFT);
    end

    // Read data multiplexer.
    always_comb begin
        int sel;
        sel = int'(bus_addr[1:0]);
        case (bus_addr)
            A_BANK0, A_BANK1, A_BANK2: bus_rdata = src_lvl[sel*LINES +: LINES];
            A_MASTER:                  bus_rdata = m_isr;
            A_MASK0, A_MASK1, A_MASK2: bus_rdata = mask_flat[sel*LINES +: LINES];
            default:                   bus_rdata = m_any ? glob_idx : 8'hFF;
        endcase
    end
endmodule

// File: rtl/casc_irq_chk.sv
// Checker for casc_irq_ctrl: temporal properties over ports and stage
// outputs. Assumes reads and writes are never issued together.
module casc_irq_chk
    import casc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_lvl,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cpu_irq,
    input logic [VEC_W-1:0]  irq_vector,
    input logic [MLINES-1:0] m_isr,
    input logic [SRC_N-1:0]  mask_flat
);
    logic ack_hit;
    assign ack_hit = bus_rd && bus_addr == A_ACK && cpu_irq;

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((src_lvl & ~mask_flat) != '0));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[2] && bus_addr != A_ACK) |=> $stable(mask_flat));

    // R4
    vec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> irq_vector == VEC_W'(VEC_BASE) + (VEC_W'($past(bus_rdata)) << VEC_SHIFT));

    // R4
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_hit |=> $stable(irq_vector));

    // R5
    master_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> $countones(m_isr) == $countones($past(m_isr)) + 1);

    // R6
    master_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASTER) |=>
            m_isr == ($past(m_isr) & ~(($past(bus_wdata[7:3]) == EOI_TAG)
                                       ? (MLINES'(1) << $past(bus_wdata[MW-1:0])) : '0)));
endmodule

bind casc_irq_ctrl casc_irq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .irq_vector (irq_vector),
    .m_isr      (m_isr),
    .mask_flat  (mask_flat)
);

// File: tb/test_casc_irq_ctrl.sv
// Bench for casc_irq_ctrl: a vector table walked by one loop, then
// directed tests for reset, nesting, ignored EOIs and spurious acks.
module test_casc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_lvl = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cpu_irq;
    logic [11:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] exp_vec = '0;
    logic [7:0]  r;

    always #4 clk = ~clk;

    casc_irq_ctrl i_casc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .irq_vector(irq_vector)
    );

    // {sources, masks, expected winner (0xFF = none)}
    localparam logic [55:0] TAB [8] = '{
        {24'h000020, 24'h000000, 8'd5},
        {24'h000408, 24'h000000, 8'd3},
        {24'h020200, 24'h000000, 8'd9},
        {24'h100004, 24'h000004, 8'd20},
        {24'h800000, 24'h000000, 8'd23},
        {24'hFFFFFF, 24'hFFFFFF, 8'hFF},
        {24'h005000, 24'h000000, 8'd12},
        {24'h010080, 24'h000080, 8'd16}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ack_read(output logic [7:0] d);
        @(negedge clk); bus_addr = 3'd7; bus_rd = 1'b1; #1 d = bus_rdata;
        if (d != 8'hFF) exp_vec = 12'h800 + 12'(d) * 12'd16;
        @(negedge clk); bus_rd = 1'b0; #1;
    endtask

    function automatic logic [7:0] casc(input int b);
        return (b == 0) ? 8'd1 : (b == 1) ? 8'd3 : 8'd4;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk); #1;
        check("R1 irq", cpu_irq, 0);
        check("R1 vector", irq_vector, 0);
        for (int k = 0; k < 3; k++) begin
            reg_read(3'(4 + k), r); check("R1 mask", r, 8'hFF);
        end
        reg_read(3'd3, r); check("R1 master isr", r, 0);
        src_lvl = '1; #1 check("R1 R2 all masked irq", cpu_irq, 0);
        src_lvl = '0;

        // Table walk: R2 R3 R4 R6
        for (int i = 0; i < 8; i++) begin
            logic [23:0] s, m;
            logic [7:0] e;
            {s, m, e} = TAB[i];
            for (int k = 0; k < 3; k++) bus_write(3'(4 + k), m[k*8 +: 8]);
            src_lvl = s; #1;
            check("R2 irq level", cpu_irq, (e != 8'hFF) ? 1 : 0);
            ack_read(r);
            check("R3 winner index", r, e);
            check("R4 vector", irq_vector, exp_vec);
            if (e != 8'hFF) begin
                bus_write(3'(e / 8), 8'hE0 | (e % 8));
                bus_write(3'd3, 8'hE0 | casc(e / 8));
            end
            src_lvl = '0; #1;
            check("R6 irq after eoi", cpu_irq, 0);
        end

        for (int k = 0; k < 3; k++) bus_write(3'(4 + k), 8'h00);

        // R5 R7 R8: master line blocks later banks and itself
        src_lvl = 24'h000010;
        ack_read(r); check("R3 idx4", r, 4);
        src_lvl = 24'h000210; #1;
        check("R5 master blocks higher line", cpu_irq, 0);
        bus_write(3'd0, 8'hE4); #1;
        check("R5 master blocks own line", cpu_irq, 0);
        reg_read(3'd3, r); check("R8 master isr line1", r, 8'h02);
        bus_write(3'd3, 8'hE1); #1;
        check("R7 rerequest", cpu_irq, 1);
        ack_read(r); check("R7 level wins again", r, 4);
        bus_write(3'd0, 8'hE4); bus_write(3'd3, 8'hE1);
        src_lvl = 24'h000200;
        ack_read(r); check("R3 idx9", r, 9);
        reg_read(3'd3, r); check("R8 master isr line3", r, 8'h08);
        bus_write(3'd1, 8'hE1); bus_write(3'd3, 8'hE3);
        src_lvl = '0;

        // R5 slave nesting inside bank 2
        src_lvl = 24'h100000;
        ack_read(r); check("R3 idx20", r, 20);
        bus_write(3'd3, 8'hE4);
        src_lvl = 24'h500000; #1;
        check("R5 slave blocks higher bit", cpu_irq, 0);
        src_lvl = 24'h520000; #1;
        check("R5 lower bit passes", cpu_irq, 1);
        ack_read(r); check("R5 nested idx17", r, 17);
        bus_write(3'd2, 8'hE1); bus_write(3'd3, 8'hE4);
        bus_write(3'd2, 8'hE4);
        src_lvl = '0; #1;
        check("R6 all cleared irq", cpu_irq, 0);
        reg_read(3'd3, r); check("R8 master isr clear", r, 0);

        // R6 ignored EOIs
        src_lvl = 24'h020000;
        ack_read(r); check("R3 idx17", r, 17);
        bus_write(3'd3, 8'hE3);
        reg_read(3'd3, r); check("R6 eoi idle line", r, 8'h10);
        bus_write(3'd3, 8'h64);
        reg_read(3'd3, r); check("R6 bad tag master", r, 8'h10);
        bus_write(3'd2, 8'h61);
        bus_write(3'd3, 8'hE4); #1;
        check("R6 bad tag slave", cpu_irq, 0);
        bus_write(3'd2, 8'hE1); #1;
        check("R7 rerequest after eoi", cpu_irq, 1);
        ack_read(r);
        bus_write(3'd2, 8'hE1); bus_write(3'd3, 8'hE4);
        src_lvl = '0;

        // R4 spurious acknowledge
        ack_read(r);
        check("R4 spurious idx", r, 8'hFF);
        check("R4 vector unchanged", irq_vector, 12'h910);

        // R2 raw levels ignore the mask
        bus_write(3'd5, 8'hFF);
        src_lvl = 24'hA53C00;
        reg_read(3'd1, r); check("R2 raw bank1", r, 8'h3C);
        reg_read(3'd2, r); check("R2 raw bank2", r, 8'hA5);
        reg_read(3'd5, r); check("R2 mask readback", r, 8'hFF);
        src_lvl = '0;

        finish_run();
    end
endmodule